// File: doc/BRIEF.md
# Backlog-Proportional Subcarrier Group Allocator

Once per allocation frame, this block decides how many subcarrier groups each of `NCL` clusters may use on a shared multi-carrier medium. Every cluster broadcasts an 8-bit queue-state value. Each node runs an identical copy of the allocator on the same broadcast data, so every node reaches the same allocation without any further negotiation. The inputs to each computation are three per-cluster values:

- the reported queue value;
- the number of groups the cluster was served in the previous frame;
- the number of flits that arrived during that frame.

The allocator works from a predicted backlog rather than from the raw queue length. The predicted backlog is the remaining demand plus a smoothed estimate of arrivals. That arrival estimate is an exponentially weighted average with a weight of 15/16, held in fixed point with 4 fraction bits. The allocator gives each cluster a rounded-up proportional share of the `NGRP` groups. One shared sequential divider computes the shares one cluster at a time. The allocator then removes any overshoot one unit at a time from the largest shares. The host raises `start_i` for one cycle. `done_o` pulses when the new shares appear on `share_o`, and `share_o` then holds them until the next completion.

Top module: `backlog_share_allocator`

## Requirements
- R1: After reset, `share_o` is all zero and `done_o` and `busy_o` are low.
- R2: For each cluster, remaining demand is the reported queue value minus the served count, and is zero when the served count is equal or larger.
- R3: For each cluster, the arrival estimate `E` is an unsigned fixed-point value with 4 fraction bits. It is reset to 0 and is updated only on an accepted start, as `E = E - floor(E/16) + arrivals`. It keeps its value across frames.
- R4: For each cluster, the expected backlog is the remaining demand plus `floor(E/16)`, using the updated `E`.
- R5: Before trimming, the share of cluster i is `ceil(NGRP * B_i / sum(B))`, where B is the expected backlog. A cluster with zero expected backlog gets zero, and every other cluster gets at least one group.
- R6: When every expected backlog is zero, every share is zero.
- R7: While the share total exceeds `NGRP`, one group is taken from the largest share, with ties going to the lowest cluster index. A non-zero result therefore sums to exactly `NGRP`.
- R8: `done_o` is a one-cycle pulse, and `share_o` changes only in the cycle `done_o` is high. A `start_i` that arrives while `busy_o` is high is ignored, and it changes neither the result nor any arrival estimate.
- R9: `busy_o` rises only in the cycle after an accepted start, and it is low whenever `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to compute a new allocation |
| qsi_i | input | NCL*QW | Reported queue values, cluster i at bits [i*QW +: QW] |
| served_i | input | NCL*SW | Groups served in the last frame, cluster i at [i*SW +: SW] |
| arrive_i | input | NCL*AW | Flits arrived in the last frame, cluster i at [i*AW +: AW] |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse when new shares are valid |
| share_o | output | NCL*SW | Allocated group count, cluster i at [i*SW +: SW] |

`SW` is `$clog2(NGRP+1)`.

## Verification
The bench builds the block with four clusters and sixteen groups. With these values the rounded-up shares overshoot the group total after only a few non-empty queues, so three-way ties for the largest share are easy to set up. The narrow served field also lets the served count exceed the queue value, and a few frames are enough to move the arrival estimate noticeably. The queue and arrival widths stay at 8 bits, so the extreme values of the queue field and the estimator are still exercised. These cover the trimming order, the clamp and the persistence of the estimator between frames.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    localparam int DEF_CLUSTERS = 32;
    localparam int DEF_GROUPS   = 256;
    localparam int DEF_QW       = 8;
    localparam int DEF_AW       = 8;
    localparam int DEF_FRAC     = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM,
        ST_DGO,
        ST_DWAIT,
        ST_TRIM,
        ST_FIN
    } alloc_state_e;

    function automatic int wmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/backlog_estimator.sv
module backlog_estimator
    import bsa_pkg::*;
#(
    parameter int QW   = DEF_QW,
    parameter int AW   = DEF_AW,
    parameter int FRAC = DEF_FRAC,
    parameter int SW   = 9,
    localparam int EW  = AW + FRAC,
    localparam int MW  = wmax(QW, AW),
    localparam int QHW = MW + 1,
    localparam int CW  = wmax(QW, SW)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           upd_i,
    input  logic [QW-1:0]  q_i,
    input  logic [SW-1:0]  served_i,
    input  logic [AW-1:0]  arrive_i,
    output logic [QHW-1:0] qhat_o
);

    logic [EW-1:0]  est_r;
    logic [EW-1:0]  est_next;
    logic [CW-1:0]  q_ext;
    logic [CW-1:0]  s_ext;
    logic [CW-1:0]  diff;
    logic [QHW-1:0] qhat_next;

    always_comb begin
        q_ext     = CW'(q_i);
        s_ext     = CW'(served_i);
        diff      = (q_ext > s_ext) ? (q_ext - s_ext) : '0;
        est_next  = est_r - (est_r >> FRAC) + EW'(arrive_i);
        qhat_next = QHW'(diff) + QHW'(est_next >> FRAC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            est_r  <= '0;
            qhat_o <= '0;
        end else if (upd_i) begin
            est_r  <= est_next;
            qhat_o <= qhat_next;
        end
    end

endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int NW = 18,
    parameter int DW = 14,
    localparam int CNW = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic          fin_o,
    output logic [NW-1:0] quo_o,
    output logic          rem_nz_o
);

    logic [NW-1:0]  quo_r;
    logic [DW-1:0]  rem_r;
    logic [DW-1:0]  den_r;
    logic [CNW-1:0] cnt_r;
    logic           run_r;
    logic [DW:0]    cand;
    logic [DW:0]    sub;
    logic           ge;

    always_comb begin
        cand = {rem_r, quo_r[NW-1]};
        sub  = cand - {1'b0, den_r};
        ge   = (cand >= {1'b0, den_r});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_r <= '0;
            rem_r <= '0;
            den_r <= '0;
            cnt_r <= '0;
            run_r <= 1'b0;
            fin_o <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            if (go_i) begin
                quo_r <= num_i;
                rem_r <= '0;
                den_r <= den_i;
                cnt_r <= CNW'(NW);
                run_r <= 1'b1;
            end else if (run_r) begin
                quo_r <= {quo_r[NW-2:0], ge};
                rem_r <= ge ? sub[DW-1:0] : cand[DW-1:0];
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CNW'(1)) begin
                    run_r <= 1'b0;
                    fin_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o    = quo_r;
    assign rem_nz_o = |rem_r;

endmodule

// File: rtl/largest_picker.sv
module largest_picker #(
    parameter int N  = 4,
    parameter int W  = 9,
    parameter int IW = 2
) (
    input  logic [N*W-1:0] vals_i,
    output logic [IW-1:0]  idx_o
);

    logic [W-1:0] best;

    always_comb begin
        best  = vals_i[W-1:0];
        idx_o = '0;
        for (int i = 1; i < N; i++) begin
            if (vals_i[i*W +: W] > best) begin
                best  = vals_i[i*W +: W];
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/backlog_share_allocator.sv
module backlog_share_allocator
    import bsa_pkg::*;
#(
    parameter int NCL  = DEF_CLUSTERS,
    parameter int NGRP = DEF_GROUPS,
    parameter int QW   = DEF_QW,
    parameter int AW   = DEF_AW,
    parameter int FRAC = DEF_FRAC,
    localparam int SW  = $clog2(NGRP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [NCL*QW-1:0] qsi_i,
    input  logic [NCL*SW-1:0] served_i,
    input  logic [NCL*AW-1:0] arrive_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [NCL*SW-1:0] share_o
);

    localparam int MW   = wmax(QW, AW);
    localparam int QHW  = MW + 1;
    localparam int IW   = (NCL > 1) ? $clog2(NCL) : 1;
    localparam int TW   = QHW + IW + 1;
    localparam int NUMW = SW + QHW;
    localparam int ACW  = SW + IW + 1;

    alloc_state_e      state_r;
    logic              upd;
    logic [QHW-1:0]    qhat [NCL];
    logic [TW-1:0]     tot_c;
    logic [TW-1:0]     tot_r;
    logic [IW-1:0]     idx_r;
    logic [ACW-1:0]    acc_r;
    logic [SW-1:0]     work [NCL];
    logic [NCL*SW-1:0] work_flat;
    logic [NUMW-1:0]   num_c;
    logic              div_go;
    logic              div_fin;
    logic [NUMW-1:0]   div_quo;
    logic              div_rem_nz;
    logic [SW-1:0]     share_new;
    logic [IW-1:0]     big_idx;

    assign upd    = start_i && (state_r == ST_IDLE);
    assign div_go = (state_r == ST_DGO);
    assign busy_o = (state_r != ST_IDLE);

    for (genvar g = 0; g < NCL; g++) begin : g_est
        backlog_estimator #(
            .QW(QW), .AW(AW), .FRAC(FRAC), .SW(SW)
        ) u_est (
            .clk      (clk),
            .rst      (rst),
            .upd_i    (upd),
            .q_i      (qsi_i[g*QW +: QW]),
            .served_i (served_i[g*SW +: SW]),
            .arrive_i (arrive_i[g*AW +: AW]),
            .qhat_o   (qhat[g])
        );
        assign work_flat[g*SW +: SW] = work[g];
    end

    always_comb begin
        tot_c = '0;
        for (int i = 0; i < NCL; i++) begin
            tot_c = tot_c + TW'(qhat[i]);
        end
        num_c     = NUMW'(NGRP) * NUMW'(qhat[idx_r]);
        share_new = div_quo[SW-1:0] + SW'(div_rem_nz);
    end

    seq_divider #(.NW(NUMW), .DW(TW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go_i     (div_go),
        .num_i    (num_c),
        .den_i    (tot_r),
        .fin_o    (div_fin),
        .quo_o    (div_quo),
        .rem_nz_o (div_rem_nz)
    );

    largest_picker #(.N(NCL), .W(SW), .IW(IW)) u_pick (
        .vals_i (work_flat),
        .idx_o  (big_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_r <= ST_IDLE;
            tot_r   <= '0;
            idx_r   <= '0;
            acc_r   <= '0;
            done_o  <= 1'b0;
            share_o <= '0;
            for (int i = 0; i < NCL; i++) work[i] <= '0;
        end else begin
            done_o <= 1'b0;
            case (state_r)
                ST_IDLE: begin
                    if (start_i) state_r <= ST_SUM;
                end
                ST_SUM: begin
                    tot_r <= tot_c;
                    idx_r <= '0;
                    acc_r <= '0;
                    for (int i = 0; i < NCL; i++) work[i] <= '0;
                    state_r <= (tot_c == '0) ? ST_FIN : ST_DGO;
                end
                ST_DGO: begin
                    state_r <= ST_DWAIT;
                end
                ST_DWAIT: begin
                    if (div_fin) begin
                        work[idx_r] <= share_new;
                        acc_r       <= acc_r + ACW'(share_new);
                        if (idx_r == IW'(NCL - 1)) begin
                            state_r <= ST_TRIM;
                        end else begin
                            idx_r   <= idx_r + 1'b1;
                            state_r <= ST_DGO;
                        end
                    end
                end
                ST_TRIM: begin
                    if (acc_r > ACW'(NGRP)) begin
                        work[big_idx] <= work[big_idx] - 1'b1;
                        acc_r         <= acc_r - 1'b1;
                    end else begin
                        state_r <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    share_o <= work_flat;
                    done_o  <= 1'b1;
                    state_r <= ST_IDLE;
                end
                default: state_r <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
    parameter int NCL  = 4,
    parameter int NGRP = 16,
    parameter int SW   = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [NCL*SW-1:0] share_o
);

    localparam int TW = SW + $clog2(NCL + 1) + 1;

    logic [TW-1:0] tot;

    always_comb begin
        tot = '0;
        for (int i = 0; i < NCL; i++) begin
            tot = tot + TW'(share_o[i*SW +: SW]);
        end
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_share_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(share_o));

    assert_sum_exact_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (tot == TW'(NGRP) || tot == '0));

    assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

endmodule

bind backlog_share_allocator bsa_checker #(
    .NCL(NCL), .NGRP(NGRP), .SW(SW)
) u_bsa_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .share_o (share_o)
);

// File: tb/test_backlog_share_allocator.sv
module test_backlog_share_allocator;

    localparam int NCL  = 4;
    localparam int NGRP = 16;
    localparam int QW   = 8;
    localparam int AW   = 8;
    localparam int SW   = $clog2(NGRP + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [NCL*QW-1:0] qsi = '0;
    logic [NCL*SW-1:0] served = '0;
    logic [NCL*AW-1:0] arrive = '0;
    logic              busy_o;
    logic              done_o;
    logic [NCL*SW-1:0] share_o;

    backlog_share_allocator #(
        .NCL(NCL), .NGRP(NGRP), .QW(QW), .AW(AW), .FRAC(4)
    ) i_backlog_share_allocator (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .qsi_i    (qsi),
        .served_i (served),
        .arrive_i (arrive),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .share_o  (share_o)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    int    frames_done = 0;
    int    exp_sh [NCL];
    int    pend_sh [NCL];
    int    est_m [NCL];
    int    qv [NCL];
    int    sv [NCL];
    int    av [NCL];
    bit    pend_v = 1'b0;
    bit    mon_on = 1'b0;
    string tag = "R1";

    task automatic chk(input string r, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, expv);
        end
    endtask

    function automatic void model();
        int qh [NCL];
        int tot;
        int sum;
        int best;
        tot = 0;
        sum = 0;
        for (int i = 0; i < NCL; i++) begin
            int rem;
            rem       = (qv[i] > sv[i]) ? qv[i] - sv[i] : 0;
            est_m[i]  = est_m[i] - est_m[i] / 16 + av[i];
            qh[i]     = rem + est_m[i] / 16;
            tot       = tot + qh[i];
        end
        for (int i = 0; i < NCL; i++) begin
            pend_sh[i] = (tot == 0) ? 0 : (NGRP * qh[i] + tot - 1) / tot;
            sum        = sum + pend_sh[i];
        end
        while (sum > NGRP) begin
            best = 0;
            for (int i = 1; i < NCL; i++) begin
                if (pend_sh[i] > pend_sh[best]) best = i;
            end
            pend_sh[best]--;
            sum--;
        end
    endfunction

    task automatic drive();
        for (int i = 0; i < NCL; i++) begin
            qsi[i*QW +: QW]    = QW'(qv[i]);
            served[i*SW +: SW] = SW'(sv[i]);
            arrive[i*AW +: AW] = AW'(av[i]);
        end
    endtask

    task automatic set_in(input int q0, q1, q2, q3, s0, s1, s2, s3, a0, a1, a2, a3);
        qv[0] = q0; qv[1] = q1; qv[2] = q2; qv[3] = q3;
        sv[0] = s0; sv[1] = s1; sv[2] = s2; sv[3] = s3;
        av[0] = a0; av[1] = a1; av[2] = a2; av[3] = a3;
    endtask

    task automatic wait_done(input string t);
        int n;
        int d0;
        n  = 0;
        d0 = frames_done;
        while (frames_done == d0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) chk(t, 0, 1, "done timeout");
        chk("R9", int'(busy_o), 0, "busy after done");
    endtask

    task automatic frame(input string t);
        @(negedge clk);
        drive();
        tag = t;
        model();
        pend_v = 1'b1;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", int'(busy_o), 1, "busy after start");
        wait_done(t);
    endtask

    // Reference comparison on every clock
    always @(negedge clk) begin
        if (mon_on) begin
            if (done_o) begin
                if (!pend_v) begin
                    chk("R8", 0, 1, "done without request");
                end else begin
                    for (int i = 0; i < NCL; i++) exp_sh[i] = pend_sh[i];
                    pend_v = 1'b0;
                    frames_done++;
                end
            end
            for (int i = 0; i < NCL; i++) begin
                chk(done_o ? tag : "R8", int'(share_o[i*SW +: SW]), exp_sh[i], "share");
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCL; i++) begin
            exp_sh[i] = 0;
            est_m[i]  = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", int'(done_o), 0, "done after reset");
        chk("R1", int'(busy_o), 0, "busy after reset");
        chk("R1", int'(share_o), 0, "shares after reset");
        mon_on = 1'b1;

        // R7: shares 6,6,6 overshoot by 2; ties trimmed lowest first -> 5,5,6,0
        set_in(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        frame("R7");
        chk("R7", exp_sh[0] * 100 + exp_sh[1] * 10 + exp_sh[2], 556, "tie order");

        // R5: 3:1 backlog -> 12,4
        set_in(3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        frame("R5");
        chk("R5", int'(share_o[0 +: SW]), 12, "proportional share c0");

        // R6: all zero
        set_in(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        frame("R6");

        // R2: served above queue clamps at zero
        set_in(5, 2, 10, 0, 9, 2, 4, 0, 0, 0, 0, 0);
        frame("R2");
        chk("R2", int'(share_o[2*SW +: SW]), 16, "only c2 keeps demand");

        // R3 and R4: arrival estimate builds and persists
        set_in(0, 0, 0, 0, 0, 0, 0, 0, 32, 16, 0, 0);
        frame("R3");
        frame("R4");
        set_in(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        frame("R3");
        chk("R3", int'(share_o[0 +: SW]), 12, "estimate kept across frames");

        // R8: start while busy is ignored
        set_in(7, 0, 0, 9, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        drive();
        tag = "R8";
        model();
        pend_v = 1'b1;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        set_in(200, 200, 200, 200, 0, 0, 0, 0, 255, 255, 255, 255);
        drive();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8");
        set_in(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        frame("R8");

        // R5 and R7 under many mixed patterns, including the queue field extremes
        set_in(255, 255, 255, 255, 0, 0, 0, 0, 255, 255, 255, 255);
        frame("R5");
        for (int k = 0; k < 20; k++) begin
            for (int i = 0; i < NCL; i++) begin
                qv[i] = int'($urandom % 256);
                sv[i] = int'($urandom % 32);
                av[i] = (k % 3 == 0) ? 0 : int'($urandom % 256);
            end
            if (k % 4 == 1) qv[k % NCL] = 0;
            frame("R7");
        end

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule